// File: doc/BRIEF.md
# ISDN Terminal Layer-1 Activation Controller

This block runs the terminal-side activation and deactivation procedure of an ISDN S/T line. A line transceiver reports its condition as 4-bit indication codes, each qualified by a one-cycle strobe. Layer 2 asks for activation with a one-cycle request. The controller tracks which F-state the line is in and sends 4-bit command codes back to the transceiver. It also reports link activation and link loss to layer 2 as one-cycle pulses. The current state is exported, and a separate flag tells the data path when frames may be sent.

A supervision timer starts each time an activation request is accepted. It is cancelled only when the link becomes fully active. If it runs out in one of the waiting states, the controller tells the transceiver to deactivate and reports a link loss to layer 2, but it stays in its current state. At most one event is handled per clock. A received indication comes first, then the activation request, then a timer expiry. An expiry that has to wait stays pending until it can be handled.

Top module: `isdn_l1_act_ctrl`

## Requirements
- R1: After reset the state output is 0 (idle reset state), `tx_allowed` is low, and every strobe output is low. State codes are: 0 reset, 1 F3 powered-down, 2 F3 powered-up, 3 F3 pending-deactivation, 4 F4, 5 F5, 6 F6, 7 F7, 8 F8.
- R2: Indication 0x1 (reset) or 0x6 (error) moves any state other than F7 to state 0 and issues command 0xF (deactivate).
- R3: Indication 0x1 or 0x6 in F7 moves to state 0, issues command 0xF and also pulses `deact_ind`.
- R4: Indication 0xC (activated) in any state other than F7 moves to F7, issues command 0x8 (activate), pulses `act_ind` and cancels the supervision timer. In F7 it has no effect. `tx_allowed` is high exactly while the state is F7.
- R5: An activation request in F3 powered-down issues command 0x8, keeps the state and restarts the supervision timer.
- R6: Indication 0x7 (power up) in F3 powered-down leads to F4. Indication 0x4 (resync) leads to F5 from F3 powered-down, F3 pending-deactivation or F4, and to F8 from F6. Indication 0x8 (activation request) leads to F6 from state 0, F3 powered-down, F3 pending-deactivation, F5 or F8.
- R7: In F7, indication 0x8 leads to F6 and indication 0x4 leads to F8. Indication 0x0 (deactivate) leads to F3 pending-deactivation and issues command 0xF. Each of these three moves pulses `deact_ind`.
- R8: Indication 0xF (clocks off) leads to F3 powered-down from state 0, F3 pending-deactivation, F4, F5, F6 and F8. Indication 0x0 in F5 or F8, and indication 0x5 in F6, lead to F3 pending-deactivation and issue command 0xF.
- R9: The timer expires exactly T3_CYCLES clocks after the edge that accepts the request. On expiry in F3 powered-down, F4, F5, F6 or F8, the block issues command 0xF and pulses `deact_ind` without changing state. In any other state the expiry is dropped and has no effect.
- R10: Any indication and state pair not listed, an activation request outside F3 powered-down, and every `deact_req`, change nothing and produce no output.
- R11: Outputs are registered. The state, command and indications change on the clock edge that follows the input cycle. `cmd_valid`, `act_ind` and `deact_ind` last one cycle, and `act_ind` and `deact_ind` are never high together.
- R12: When several events arrive in one cycle, an indication wins over an activation request, which wins over a pending expiry. A request that loses is dropped. An expiry that loses stays pending and is handled in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_valid | input | 1 | Strobe for `ind_code` |
| ind_code | input | 4 | Indication code from the transceiver |
| act_req | input | 1 | Activation request from layer 2 (one cycle) |
| deact_req | input | 1 | Deactivation request from layer 2 (accepted, no effect) |
| cmd_valid | output | 1 | One-cycle strobe for `cmd_code` |
| cmd_code | output | 4 | Command code to the transceiver (0 when not valid) |
| act_ind | output | 1 | One-cycle link-activated pulse to layer 2 |
| deact_ind | output | 1 | One-cycle link-lost pulse to layer 2 |
| l1_state | output | 4 | Current state code |
| tx_allowed | output | 1 | High while the link is fully active (F7) |

## Verification
A wrong internal state shows on `l1_state` on the edge right after the event that caused it. The bench compares every output against a behavioural model on every clock, so such a fault is seen within one cycle. A fault in the supervision timer is harder to see, because it only shows when the timer expires. A late, early or lost expiry therefore becomes visible only T3_CYCLES clocks after the request, and only when the controller is still in a waiting state. For this reason the bench lets the timer run out in several waiting states. It also lets it run out in a state where the expiry must be dropped, after a cancellation, and during a burst of indications that forces the expiry to wait.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_F3_OFF  = 4'd1,
        ST_F3_ON   = 4'd2,
        ST_F3_WAIT = 4'd3,
        ST_F4      = 4'd4,
        ST_F5      = 4'd5,
        ST_F6      = 4'd6,
        ST_F7      = 4'd7,
        ST_F8      = 4'd8
    } l1_state_e;

    // Indications received from the transceiver
    localparam logic [3:0] IND_DEACT      = 4'h0;
    localparam logic [3:0] IND_RESET      = 4'h1;
    localparam logic [3:0] IND_TEST       = 4'h2;
    localparam logic [3:0] IND_SLIP       = 4'h3;
    localparam logic [3:0] IND_RESYNC     = 4'h4;
    localparam logic [3:0] IND_DEACT6     = 4'h5;
    localparam logic [3:0] IND_ERROR      = 4'h6;
    localparam logic [3:0] IND_PWRUP      = 4'h7;
    localparam logic [3:0] IND_ACT_REQ    = 4'h8;
    localparam logic [3:0] IND_LOOP_REQ   = 4'hA;
    localparam logic [3:0] IND_CODE_VIOL  = 4'hB;
    localparam logic [3:0] IND_ACT8       = 4'hC;
    localparam logic [3:0] IND_ACT10      = 4'hD;
    localparam logic [3:0] IND_ACT_LOOP   = 4'hE;
    localparam logic [3:0] IND_CLOCKS_OFF = 4'hF;

    // Commands sent to the transceiver
    localparam logic [3:0] CMD_TIMING    = 4'h0;
    localparam logic [3:0] CMD_RESET     = 4'h1;
    localparam logic [3:0] CMD_SEND_POS  = 4'h2;
    localparam logic [3:0] CMD_SEND_CONT = 4'h3;
    localparam logic [3:0] CMD_ACT8      = 4'h8;
    localparam logic [3:0] CMD_ACT10     = 4'h9;
    localparam logic [3:0] CMD_LOOP      = 4'hA;
    localparam logic [3:0] CMD_DEACT     = 4'hF;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_IND    = 2'd1,
        EV_ACT    = 2'd2,
        EV_EXPIRE = 2'd3
    } l1_ev_kind_e;

    typedef struct packed {
        l1_ev_kind_e kind;
        logic [3:0]  code;
    } l1_event_t;

endpackage

// File: rtl/l1act_event_sel.sv
module l1act_event_sel
    import l1act_pkg::*;
(
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       exp_pend,
    output l1_event_t  ev,
    output logic       exp_ack
);

    // One event per cycle: indication, then request, then timer expiry.
    always_comb begin
        ev.kind = EV_NONE;
        ev.code = 4'h0;
        exp_ack = 1'b0;
        if (ind_valid) begin
            ev.kind = EV_IND;
            ev.code = ind_code;
        end else if (act_req) begin
            ev.kind = EV_ACT;
        end else if (exp_pend) begin
            ev.kind = EV_EXPIRE;
            exp_ack = 1'b1;
        end
    end

endmodule

// File: rtl/l1act_t3_timer.sv
module l1act_t3_timer #(
    parameter int unsigned T3_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cancel,
    input  logic ack,
    output logic pend
);

    localparam int unsigned CW = $clog2(T3_CYCLES + 1);
    localparam logic [CW-1:0] T3_LOAD = CW'(T3_CYCLES);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } t3_regs_t;

    t3_regs_t t3_q, t3_d;

    always_comb begin
        t3_d = t3_q;
        if (cancel) begin
            t3_d.cnt  = '0;
            t3_d.pend = 1'b0;
        end else if (arm) begin
            t3_d.cnt  = T3_LOAD;
            t3_d.pend = 1'b0;
        end else begin
            if (ack) begin
                t3_d.pend = 1'b0;
            end
            if (t3_q.cnt != '0) begin
                t3_d.cnt = t3_q.cnt - ONE;
                if (t3_q.cnt == ONE) begin
                    t3_d.pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t3_q <= '0;
        end else begin
            t3_q <= t3_d;
        end
    end

    assign pend = t3_q.pend;

    // R5: a restart reloads the full window and drops any old expiry
    assert_arm_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !cancel) |=> (t3_q.cnt == T3_LOAD && !pend));

    // R4: cancellation leaves neither a count nor a pending expiry
    assert_cancel_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (t3_q.cnt == '0 && !pend));

    // R12: an expiry that is not taken stays pending
    assert_pend_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack && !cancel && !arm) |=> pend);

endmodule

// File: rtl/l1act_fsm.sv
module l1act_fsm
    import l1act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  l1_event_t  ev,
    output l1_state_e  state,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       act_ind,
    output logic       deact_ind,
    output logic       t3_arm,
    output logic       t3_cancel
);

    typedef struct packed {
        l1_state_e  state;
        logic       cmd_v;
        logic [3:0] cmd;
        logic       act;
        logic       deact;
    } fsm_regs_t;

    fsm_regs_t fsm_q, fsm_d;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.cmd_v = 1'b0;
        fsm_d.cmd   = 4'h0;
        fsm_d.act   = 1'b0;
        fsm_d.deact = 1'b0;
        t3_arm      = 1'b0;
        t3_cancel   = 1'b0;

        unique case (ev.kind)
            EV_IND: begin
                case (ev.code)
                    IND_RESET, IND_ERROR: begin
                        fsm_d.state = ST_RESET;
                        fsm_d.cmd_v = 1'b1;
                        fsm_d.cmd   = CMD_DEACT;
                        fsm_d.deact = (fsm_q.state == ST_F7);
                    end
                    IND_ACT8: begin
                        if (fsm_q.state != ST_F7) begin
                            fsm_d.state = ST_F7;
                            fsm_d.cmd_v = 1'b1;
                            fsm_d.cmd   = CMD_ACT8;
                            fsm_d.act   = 1'b1;
                            t3_cancel   = 1'b1;
                        end
                    end
                    IND_CLOCKS_OFF: begin
                        if (fsm_q.state inside {ST_RESET, ST_F3_WAIT, ST_F4,
                                                ST_F5, ST_F6, ST_F8}) begin
                            fsm_d.state = ST_F3_OFF;
                        end
                    end
                    IND_ACT_REQ: begin
                        if (fsm_q.state inside {ST_RESET, ST_F3_OFF, ST_F3_WAIT,
                                                ST_F5, ST_F8}) begin
                            fsm_d.state = ST_F6;
                        end else if (fsm_q.state == ST_F7) begin
                            fsm_d.state = ST_F6;
                            fsm_d.deact = 1'b1;
                        end
                    end
                    IND_RESYNC: begin
                        if (fsm_q.state inside {ST_F3_OFF, ST_F3_WAIT, ST_F4}) begin
                            fsm_d.state = ST_F5;
                        end else if (fsm_q.state == ST_F6) begin
                            fsm_d.state = ST_F8;
                        end else if (fsm_q.state == ST_F7) begin
                            fsm_d.state = ST_F8;
                            fsm_d.deact = 1'b1;
                        end
                    end
                    IND_PWRUP: begin
                        if (fsm_q.state == ST_F3_OFF) begin
                            fsm_d.state = ST_F4;
                        end
                    end
                    IND_DEACT: begin
                        if (fsm_q.state inside {ST_F5, ST_F7, ST_F8}) begin
                            fsm_d.state = ST_F3_WAIT;
                            fsm_d.cmd_v = 1'b1;
                            fsm_d.cmd   = CMD_DEACT;
                            fsm_d.deact = (fsm_q.state == ST_F7);
                        end
                    end
                    IND_DEACT6: begin
                        if (fsm_q.state == ST_F6) begin
                            fsm_d.state = ST_F3_WAIT;
                            fsm_d.cmd_v = 1'b1;
                            fsm_d.cmd   = CMD_DEACT;
                        end
                    end
                    default: ;
                endcase
            end
            EV_ACT: begin
                if (fsm_q.state == ST_F3_OFF) begin
                    fsm_d.cmd_v = 1'b1;
                    fsm_d.cmd   = CMD_ACT8;
                    t3_arm      = 1'b1;
                end
            end
            EV_EXPIRE: begin
                if (fsm_q.state inside {ST_F3_OFF, ST_F4, ST_F5, ST_F6, ST_F8}) begin
                    fsm_d.cmd_v = 1'b1;
                    fsm_d.cmd   = CMD_DEACT;
                    fsm_d.deact = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_RESET, cmd_v: 1'b0, cmd: 4'h0, act: 1'b0, deact: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state     = fsm_q.state;
    assign cmd_valid = fsm_q.cmd_v;
    assign cmd_code  = fsm_q.cmd;
    assign act_ind   = fsm_q.act;
    assign deact_ind = fsm_q.deact;

    // R1: the state register never holds an unused code
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state <= ST_F8));

    // R2: reset or error indication always lands in the reset state with a deactivate command
    assert_reset_ind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.kind == EV_IND && (ev.code == IND_RESET || ev.code == IND_ERROR))
        |=> (state == ST_RESET && cmd_valid && cmd_code == CMD_DEACT));

    // R4: an activation pulse comes only with the full-activation state and its command
    assert_act_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_ind |-> (state == ST_F7 && cmd_valid && cmd_code == CMD_ACT8));

    // R11: activation and deactivation pulses are exclusive
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_ind && deact_ind));

    // R9: a timer expiry never moves the state
    assert_expire_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.kind == EV_EXPIRE) |=> (state == $past(state)));

endmodule

// File: rtl/isdn_l1_act_ctrl.sv
module isdn_l1_act_ctrl
    import l1act_pkg::*;
#(
    parameter int unsigned T3_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       deact_req,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       act_ind,
    output logic       deact_ind,
    output logic [3:0] l1_state,
    output logic       tx_allowed
);

    l1_event_t ev;
    l1_state_e state;
    logic      exp_pend;
    logic      exp_ack;
    logic      t3_arm;
    logic      t3_cancel;

    l1act_event_sel u_sel (
        .ind_valid (ind_valid),
        .ind_code  (ind_code),
        .act_req   (act_req),
        .exp_pend  (exp_pend),
        .ev        (ev),
        .exp_ack   (exp_ack)
    );

    l1act_t3_timer #(.T3_CYCLES(T3_CYCLES)) u_t3 (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (t3_arm),
        .cancel (t3_cancel),
        .ack    (exp_ack),
        .pend   (exp_pend)
    );

    l1act_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .state     (state),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .act_ind   (act_ind),
        .deact_ind (deact_ind),
        .t3_arm    (t3_arm),
        .t3_cancel (t3_cancel)
    );

    assign l1_state   = state;
    assign tx_allowed = (state == ST_F7);

    // R10: a lone deactivation request has no effect at the ports
    assert_deact_req_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_req && !ind_valid && !act_req && !exp_pend)
        |=> (!cmd_valid && !act_ind && !deact_ind && $stable(l1_state)));

    // R12: an indication pre-empts a coincident request (no activate command results)
    assert_ind_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid && act_req && ind_code != IND_ACT8) |=> !(cmd_valid && cmd_code == CMD_ACT8));

endmodule

// File: tb/isdn_l1_act_ctrl_test.sv
`timescale 1ns/1ps
module isdn_l1_act_ctrl_test;

    localparam int T3 = 40;

    // state codes
    localparam int S_RST = 0, S_OFF = 1, S_ON = 2, S_WAIT = 3, S_F4 = 4,
                   S_F5 = 5, S_F6 = 6, S_F7 = 7, S_F8 = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ind_valid = 1'b0;
    logic [3:0] ind_code = 4'h0;
    logic       act_req = 1'b0;
    logic       deact_req = 1'b0;
    logic       cmd_valid;
    logic [3:0] cmd_code;
    logic       act_ind;
    logic       deact_ind;
    logic [3:0] l1_state;
    logic       tx_allowed;

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    int m_state = S_RST;
    int m_cnt   = 0;
    bit m_pend  = 0;
    bit e_cv; logic [3:0] e_cmd; bit e_act; bit e_deact;

    always #2.5 clk = ~clk;

    isdn_l1_act_ctrl #(.T3_CYCLES(T3)) uut (
        .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
        .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .act_ind(act_ind), .deact_ind(deact_ind),
        .l1_state(l1_state), .tx_allowed(tx_allowed)
    );

    task automatic model(input bit iv, input logic [3:0] ic, input bit ar);
        bit arm = 0, cancel = 0, ack = 0;
        int s = m_state;
        e_cv = 0; e_cmd = 4'h0; e_act = 0; e_deact = 0;
        if (iv) begin
            if (ic == 4'h1 || ic == 4'h6) begin
                e_deact = (s == S_F7); m_state = S_RST; e_cv = 1; e_cmd = 4'hF;
            end else if (ic == 4'hC) begin
                if (s != S_F7) begin
                    m_state = S_F7; e_cv = 1; e_cmd = 4'h8; e_act = 1; cancel = 1;
                end
            end else if (ic == 4'hF) begin
                if (s == S_RST || s == S_WAIT || s == S_F4 || s == S_F5 || s == S_F6 || s == S_F8)
                    m_state = S_OFF;
            end else if (ic == 4'h8) begin
                if (s == S_RST || s == S_OFF || s == S_WAIT || s == S_F5 || s == S_F8) m_state = S_F6;
                else if (s == S_F7) begin m_state = S_F6; e_deact = 1; end
            end else if (ic == 4'h4) begin
                if (s == S_OFF || s == S_WAIT || s == S_F4) m_state = S_F5;
                else if (s == S_F6) m_state = S_F8;
                else if (s == S_F7) begin m_state = S_F8; e_deact = 1; end
            end else if (ic == 4'h7) begin
                if (s == S_OFF) m_state = S_F4;
            end else if (ic == 4'h0) begin
                if (s == S_F5 || s == S_F8 || s == S_F7) begin
                    e_deact = (s == S_F7); m_state = S_WAIT; e_cv = 1; e_cmd = 4'hF;
                end
            end else if (ic == 4'h5) begin
                if (s == S_F6) begin m_state = S_WAIT; e_cv = 1; e_cmd = 4'hF; end
            end
        end else if (ar) begin
            if (s == S_OFF) begin e_cv = 1; e_cmd = 4'h8; arm = 1; end
        end else if (m_pend) begin
            ack = 1;
            if (s == S_OFF || s == S_F4 || s == S_F5 || s == S_F6 || s == S_F8) begin
                e_cv = 1; e_cmd = 4'hF; e_deact = 1;
            end
        end
        if (cancel) begin m_cnt = 0; m_pend = 0; end
        else if (arm) begin m_cnt = T3; m_pend = 0; end
        else begin
            if (ack) m_pend = 0;
            if (m_cnt > 0) begin
                if (m_cnt == 1) m_pend = 1;
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [11:0] act_v, exp_v;
        act_v = {l1_state, cmd_valid, cmd_code, act_ind, deact_ind, tx_allowed};
        exp_v = {4'(m_state), e_cv, e_cmd, e_act, e_deact, (m_state == S_F7)};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s t=%0t actual state=%0d cv=%0b cmd=%h act=%0b deact=%0b tx=%0b expected state=%0d cv=%0b cmd=%h act=%0b deact=%0b tx=%0b",
                     tag, $time, act_v[11:8], act_v[7], act_v[6:3], act_v[2], act_v[1], act_v[0],
                     exp_v[11:8], exp_v[7], exp_v[6:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic step(input bit iv, input logic [3:0] ic, input bit ar, input bit dr, input string tag);
        ind_valid = iv; ind_code = ic; act_req = ar; deact_req = dr;
        model(iv, ic, ar);
        @(posedge clk);
        @(negedge clk);
        ind_valid = 0; ind_code = 4'h0; act_req = 0; deact_req = 0;
        compare(tag);
    endtask

    task automatic ind(input logic [3:0] c, input string tag);
        step(1, c, 0, 0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 4'h0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_cv = 0; e_cmd = 0; e_act = 0; e_deact = 0;
        compare("R1");                       // reset state
        idle(2, "R1");
        step(0, 4'h0, 0, 1, "R10");          // deact_req ignored
        step(0, 4'h0, 1, 0, "R10");          // request outside F3 powered-down
        ind(4'h1, "R2");                     // reset ind in reset state
        ind(4'h2, "R10");                    // test ind ignored
        ind(4'hF, "R8");                     // -> F3 powered-down
        step(0, 4'h0, 1, 0, "R5");           // arm timer, AR8
        idle(T3 + 3, "R9");                  // expiry in F3 powered-down
        ind(4'h7, "R6");                     // -> F4
        ind(4'h4, "R6");                     // -> F5
        ind(4'h8, "R6");                     // -> F6
        ind(4'h4, "R6");                     // -> F8
        ind(4'hC, "R4");                     // -> F7
        ind(4'hC, "R4");                     // ignored in F7
        ind(4'hB, "R10");                    // ignored in F7
        step(0, 4'h0, 0, 1, "R10");
        ind(4'h4, "R7");                     // F7 -> F8 with deact
        ind(4'h0, "R8");                     // F8 -> pending deact
        ind(4'h8, "R6");                     // -> F6
        ind(4'h5, "R8");                     // -> pending deact
        ind(4'hF, "R8");                     // -> F3 powered-down
        step(0, 4'h0, 1, 0, "R5");
        idle(10, "R5");
        ind(4'hC, "R4");                     // cancel timer
        idle(T3 + 5, "R4");                  // no expiry
        ind(4'h8, "R7");                     // F7 -> F6 deact
        ind(4'hC, "R4");
        ind(4'h0, "R7");                     // F7 -> pending, DI, deact
        ind(4'hC, "R4");
        ind(4'h6, "R3");                     // F7 error -> reset, DI, deact
        ind(4'hF, "R8");
        step(0, 4'h0, 1, 0, "R5");
        ind(4'h7, "R6");                     // F4 with timer running
        step(0, 4'h0, 1, 0, "R10");          // request in F4 ignored
        idle(T3 + 2, "R9");                  // expiry in F4, stays F4
        ind(4'h4, "R6");                     // F5
        ind(4'h0, "R8");                     // F5 DR -> pending
        ind(4'hF, "R8");
        step(1, 4'h7, 1, 0, "R12");          // indication wins, request dropped
        ind(4'hF, "R8");
        step(0, 4'h0, 1, 0, "R5");
        ind(4'h4, "R6");                     // F5
        idle(T3 - 3, "R12");
        for (int i = 0; i < 6; i++) ind(4'h3, "R12");  // hold off expiry
        idle(3, "R12");                      // deferred expiry in F5
        ind(4'hF, "R8");
        step(0, 4'h0, 1, 0, "R5");
        ind(4'h1, "R2");                     // reset state, timer still runs
        idle(T3 + 2, "R9");                  // expiry dropped in reset state
        ind(4'hF, "R8");
        step(0, 4'h0, 1, 0, "R5");
        ind(4'h8, "R6");                     // F6
        idle(T3, "R9");                      // expiry in F6
        ind(4'h1, "R2");
        idle(2, "R11");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule